// File: doc/BRIEF.md
# Backplane Static RAM Card Address Decode and Byte-Lane Control

This block decides whether a static RAM card answers a backplane bus cycle. It also controls the data paths used for that cycle. The bus carries 24-bit addresses and moves data 8 or 16 bits at a time. The card answers only in the lower half of the address space, from 000000h to 7FFFFFh.

The card stays silent in three cases:
- an interrupt-acknowledge, port-input or port-output status is active;
- the active-low phantom line is asserted, so that another device can overlay its range;
- address bit 23 is high.

When the card answers, two buffer enables steer the bytes. One serves the odd (high) byte lane and one serves the even (low) byte lane. The choice depends on address bit 0 and on whether the transfer is 8-bit or 16-bit. The block also drives the chip and write enables of two 4 MB SRAM devices, which together form an 8 MB array. Address bit 22 picks one device, and address bits 21..1 give the word inside it.

The devices are modelled behaviourally inside the block. Their stored depth is a parameter, and the default keeps only a small window of words. Bus arbitration, wait states and the electrical drivers are handled elsewhere.

Top module: `mem_board_decode`

## Requirements
- R1: While any of st_inta, st_inp or st_out is high, board_sel_n is high. In the same condition both lane enables, both sram_ce_n bits and both SRAM write enables are high (inactive), whatever the other inputs are.
- R2: While phantom_n is low, the card is deselected in the same way as in R1.
- R3: While addr[23] is 1 (addresses 800000h and above), the card is deselected in the same way as in R1. Neither data lane is driven and no write takes place.
- R4: lane_hi_oe_n is low exactly when the card is selected, st_sync is low, and at least one of these holds: (rd8_n low and addr[0]=1), rd16_n low, or wr16_n low.
- R5: lane_lo_oe_n is low only for an 8-bit read (rd8_n low) with addr[0]=0, while the card is selected and st_sync is low.
- R6: While st_sync is high, both lane enables, both sram_ce_n bits, both SRAM write enables and sram_oe_n are high.
- R7: When the card is selected, st_sync is low and any read or write qualifier is low, exactly one of two bits is low: sram_ce_n[0] when addr[22]=0, or sram_ce_n[1] when addr[22]=1. Otherwise both bits are high.
- R8: An 8-bit write (wr8_n low) lowers only one write enable, picked by addr[0]. For addr[0]=1 it lowers sram_we_hi_n, and for addr[0]=0 it lowers sram_we_lo_n. wr_data[7:0] is stored into that byte at the clock edge, and the other byte of the word keeps its value.
- R9: A 16-bit write (wr16_n low) lowers both write enables. At the clock edge it stores wr_data[15:8] into the odd byte and wr_data[7:0] into the even byte; addr[0] plays no part.
- R10: sram_oe_n is low only when the card is selected, st_sync is low, st_memr is high and a read qualifier is low. While it is low, rd_data holds the stored word as {odd, even} for a 16-bit read. For an 8-bit read it holds {8'h00, byte chosen by addr[0]}. While it is high, rd_data is zero.
- R11: Inside a device, the stored word index is addr[MODEL_AW:1], with MODEL_AW = 6 by default. Address bits above that index and below bit 22 select the same stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; SRAM writes take effect on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; blocks writes while low |
| st_inta | input | 1 | Interrupt-acknowledge status, active high |
| st_inp | input | 1 | Port-input status, active high |
| st_out | input | 1 | Port-output status, active high |
| st_memr | input | 1 | Memory-read status, active high |
| st_sync | input | 1 | Address-phase sync, active high |
| phantom_n | input | 1 | Overlay request, active low |
| addr | input | 24 | Bus address |
| rd8_n | input | 1 | 8-bit read qualifier, active low |
| rd16_n | input | 1 | 16-bit read qualifier, active low |
| wr8_n | input | 1 | 8-bit write qualifier, active low |
| wr16_n | input | 1 | 16-bit write qualifier, active low |
| wr_data | input | 16 | Write data, odd byte in [15:8], even byte in [7:0] |
| rd_data | output | 16 | Read data formatted per R10 |
| lane_hi_oe_n | output | 1 | Odd/high lane buffer enable, active low |
| lane_lo_oe_n | output | 1 | Even/low lane buffer enable, active low |
| sram_ce_n | output | 2 | Per-device chip enables, active low |
| sram_we_hi_n | output | 1 | Odd-byte write enable, active low |
| sram_we_lo_n | output | 1 | Even-byte write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| board_sel_n | output | 1 | Board select, active low |

## Verification
A deselecting condition can arrive in the same cycle as a valid write qualifier. The cases are a phantom request, an I/O status, address bit 23 or the sync phase, each together with a 16-bit write. The bench drives each such pair in one cycle to a word that already holds known data. It judges the outcome twice: the write enables must stay high in that cycle, and a later 16-bit read of the word must still return the old contents. For the bit-23 case, the write goes to an address that would reach the same stored word if the decode ignored that bit.

// File: rtl/mbd_pkg.sv
// Package: shared types for the memory card decode.
// Assumes: all bus status lines are sampled as active-high levels.
package mbd_pkg;

    // Bus status lines that take part in the board select decision.
    typedef struct packed {
        logic inta;
        logic inp;
        logic outp;
        logic memr;
        logic sync;
    } bus_status_t;

    // Which bytes of the addressed word a write cycle updates.
    typedef enum logic [1:0] {
        WK_NONE = 2'b00,
        WK_EVEN = 2'b01,
        WK_ODD  = 2'b10,
        WK_BOTH = 2'b11
    } wr_kind_t;

endpackage

// File: rtl/mbd_select.sv
// Module: mbd_select
// Decides whether the card answers the current bus cycle. Any I/O or
// interrupt status, an asserted phantom line or the top address bit
// deselects. 'active' adds the data-phase condition (sync low).
// Assumes: inputs are stable levels for the whole bus cycle.
module mbd_select
    import mbd_pkg::*;
(
    input  bus_status_t status,
    input  logic        phantom_n,
    input  logic        addr_top,
    output logic        selected,
    output logic        active
);

    // Combine deselect terms into the board select level.
    always_comb begin
        selected = ~(status.inta | status.inp | status.outp | ~phantom_n | addr_top);
        active   = selected & ~status.sync;
    end

endmodule

// File: rtl/mbd_lane.sv
// Module: mbd_lane
// Byte-lane steering: lane buffer enables, per-byte write enables,
// SRAM output enable and formatting of read data onto the bus.
// Assumes: 'active' already includes board select and sync low.
module mbd_lane
    import mbd_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int BYTE_W = DATA_W / 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              memr,
    input  logic              a0,
    input  logic              rd8_n,
    input  logic              rd16_n,
    input  logic              wr8_n,
    input  logic              wr16_n,
    input  logic [DATA_W-1:0] word_in,
    output logic              hi_oe_n,
    output logic              lo_oe_n,
    output logic              we_hi_n,
    output logic              we_lo_n,
    output logic              sram_oe_n,
    output logic              any_access,
    output logic [DATA_W-1:0] rd_data
);

    wr_kind_t wkind;
    logic     is_rd;
    logic     is_rd8;
    logic     is_rd16;

    // Decode the qualifiers into read kind and write byte coverage.
    always_comb begin
        is_rd8  = ~rd8_n;
        is_rd16 = ~rd16_n;
        is_rd   = is_rd8 | is_rd16;
        if (!wr16_n)
            wkind = WK_BOTH;
        else if (!wr8_n)
            wkind = a0 ? WK_ODD : WK_EVEN;
        else
            wkind = WK_NONE;
    end

    // Drive lane buffer enables from transfer size and byte address.
    always_comb begin
        hi_oe_n = ~(active & ((is_rd8 & a0) | is_rd16 | ~wr16_n));
        lo_oe_n = ~(active & is_rd8 & ~a0);
    end

    // Drive SRAM write/output enables and the access indication.
    always_comb begin
        we_hi_n    = ~(active & wkind[1]);
        we_lo_n    = ~(active & wkind[0]);
        sram_oe_n  = ~(active & memr & is_rd);
        any_access = active & (is_rd | (wkind != WK_NONE));
    end

    // Format stored word onto the read data bus.
    always_comb begin
        if (sram_oe_n)
            rd_data = '0;
        else if (is_rd16)
            rd_data = word_in;
        else if (a0)
            rd_data = {{BYTE_W{1'b0}}, word_in[DATA_W-1:BYTE_W]};
        else
            rd_data = {{BYTE_W{1'b0}}, word_in[BYTE_W-1:0]};
    end

    // R5: even lane opens only for an 8-bit read at an even address.
    a_r5_lo_only_even_rd8: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_oe_n |-> (!rd8_n && !a0));

    // R8: an 8-bit-only write never touches both bytes.
    a_r8_single_byte_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr8_n && wr16_n) |-> (we_hi_n || we_lo_n));

    // R10: data bus stays zero whenever the SRAM is not read.
    a_r10_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sram_oe_n |-> (rd_data == '0));

endmodule

// File: rtl/mbd_sram_bank.sv
// Module: mbd_sram_bank
// Behavioural model of one SRAM device with separate byte write enables
// and an asynchronous read. Only 2**MODEL_AW words are stored; higher
// word-address bits alias onto them.
// Assumes: writes are sampled at the rising clock edge.
module mbd_sram_bank #(
    parameter int DATA_W   = 16,
    parameter int MODEL_AW = 6,
    localparam int BYTE_W  = DATA_W / 2,
    localparam int DEPTH   = 1 << MODEL_AW
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_hi_n,
    input  logic                we_lo_n,
    input  logic [MODEL_AW-1:0] widx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store enabled bytes at the clock edge; reset blocks all writes.
    always_ff @(posedge clk) begin
        if (rst_n && !ce_n) begin
            if (!we_hi_n)
                mem[widx][DATA_W-1:BYTE_W] <= wdata[DATA_W-1:BYTE_W];
            if (!we_lo_n)
                mem[widx][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
        end
    end

    // Asynchronous read of the addressed word.
    always_comb begin
        rdata = mem[widx];
    end

endmodule

// File: rtl/mem_board_decode.sv
// Module: mem_board_decode (top)
// Address decode and byte-lane control for a static RAM card that answers
// in the lower half of a 24-bit bus space, split over two SRAM devices.
// Assumes: one bus cycle per clock as seen by this block; 8-bit writes
// carry their byte on wr_data[7:0].
module mem_board_decode
    import mbd_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int MODEL_AW = 6,
    localparam int TOP_BIT   = ADDR_W - 1,
    localparam int BANK_BIT  = ADDR_W - 2,
    localparam int NUM_BANKS = 2,
    localparam int BYTE_W    = DATA_W / 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_inta,
    input  logic              st_inp,
    input  logic              st_out,
    input  logic              st_memr,
    input  logic              st_sync,
    input  logic              phantom_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd8_n,
    input  logic              rd16_n,
    input  logic              wr8_n,
    input  logic              wr16_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              lane_hi_oe_n,
    output logic              lane_lo_oe_n,
    output logic [NUM_BANKS-1:0] sram_ce_n,
    output logic              sram_we_hi_n,
    output logic              sram_we_lo_n,
    output logic              sram_oe_n,
    output logic              board_sel_n
);

    bus_status_t              status;
    logic                     selected;
    logic                     active;
    logic                     any_access;
    logic [DATA_W-1:0]        bank_word [NUM_BANKS];
    logic [DATA_W-1:0]        word_sel;
    logic [DATA_W-1:0]        wdata_bank;
    logic [MODEL_AW-1:0]      widx;
    logic                     unused_addr_bits;

    // Gather status lines into the shared struct.
    always_comb begin
        status = '{inta: st_inta, inp: st_inp, outp: st_out,
                   memr: st_memr, sync: st_sync};
    end

    mbd_select u_select (
        .status    (status),
        .phantom_n (phantom_n),
        .addr_top  (addr[TOP_BIT]),
        .selected  (selected),
        .active    (active)
    );

    mbd_lane #(.DATA_W(DATA_W)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .memr       (st_memr),
        .a0         (addr[0]),
        .rd8_n      (rd8_n),
        .rd16_n     (rd16_n),
        .wr8_n      (wr8_n),
        .wr16_n     (wr16_n),
        .word_in    (word_sel),
        .hi_oe_n    (lane_hi_oe_n),
        .lo_oe_n    (lane_lo_oe_n),
        .we_hi_n    (sram_we_hi_n),
        .we_lo_n    (sram_we_lo_n),
        .sram_oe_n  (sram_oe_n),
        .any_access (any_access),
        .rd_data    (rd_data)
    );

    // Word index, bank-side write data and the unused-address fold.
    always_comb begin
        widx             = addr[MODEL_AW:1];
        board_sel_n      = ~selected;
        unused_addr_bits = ^addr[BANK_BIT-1:MODEL_AW+1];
        if (!wr16_n)
            wdata_bank = wr_data;
        else
            wdata_bank = {wr_data[BYTE_W-1:0], wr_data[BYTE_W-1:0]};
    end

    // One chip enable and one device model per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Chip enable for this bank from the bank-select address bit.
        always_comb begin
            sram_ce_n[b] = ~(any_access && (addr[BANK_BIT] == b[0]));
        end

        mbd_sram_bank #(.DATA_W(DATA_W), .MODEL_AW(MODEL_AW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce_n    (sram_ce_n[b]),
            .we_hi_n (sram_we_hi_n),
            .we_lo_n (sram_we_lo_n),
            .widx    (widx),
            .wdata   (wdata_bank),
            .rdata   (bank_word[b])
        );
    end

    // Pick the addressed bank's word for the read path.
    always_comb begin
        word_sel = bank_word[addr[BANK_BIT]];
    end

    // R1: I/O or interrupt status keeps the card silent.
    a_r1_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_inta || st_inp || st_out) |->
        (board_sel_n && lane_hi_oe_n && lane_lo_oe_n && (&sram_ce_n)
         && sram_we_hi_n && sram_we_lo_n));

    // R2: phantom overlay keeps the card silent.
    a_r2_phantom_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !phantom_n |->
        (board_sel_n && lane_hi_oe_n && lane_lo_oe_n && (&sram_ce_n)));

    // R3: upper half of the address space is never answered.
    a_r3_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        addr[TOP_BIT] |->
        (lane_hi_oe_n && lane_lo_oe_n && sram_we_hi_n && sram_we_lo_n));

    // R6: address phase leaves lanes and SRAM idle.
    a_r6_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st_sync |->
        (lane_hi_oe_n && lane_lo_oe_n && (&sram_ce_n) && sram_oe_n));

    // R7: at most one device is enabled at a time.
    a_r7_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sram_ce_n));

    // R9: a 16-bit write in the data phase enables both bytes.
    a_r9_word_we: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_hi_n && !wr16_n) |-> !sram_we_lo_n);

endmodule

// File: tb/mem_board_decode_tb.sv
// Scoreboard bench: a driver task applies one bus cycle per clock and
// pushes the expected port values; a monitor pops and compares.
module mem_board_decode_tb;

    typedef struct packed {
        logic        sel_n;
        logic        hi_n;
        logic        lo_n;
        logic [1:0]  ce_n;
        logic        we_hi_n;
        logic        we_lo_n;
        logic        oe_n;
        logic [15:0] data;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_inta = 1'b0, st_inp = 1'b0, st_out = 1'b0;
    logic        st_memr = 1'b0, st_sync = 1'b0, phantom_n = 1'b1;
    logic [23:0] addr = '0;
    logic        rd8_n = 1'b1, rd16_n = 1'b1, wr8_n = 1'b1, wr16_n = 1'b1;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        lane_hi_oe_n, lane_lo_oe_n, sram_we_hi_n, sram_we_lo_n;
    logic        sram_oe_n, board_sel_n;
    logic [1:0]  sram_ce_n;

    int          checks = 0;
    int          failures = 0;
    obs_t        exp_q [$];
    string       tag_q [$];
    logic [15:0] shadow [2][64];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mem_board_decode u_dut (
        .clk (clk), .rst_n (rst_n),
        .st_inta (st_inta), .st_inp (st_inp), .st_out (st_out),
        .st_memr (st_memr), .st_sync (st_sync), .phantom_n (phantom_n),
        .addr (addr), .rd8_n (rd8_n), .rd16_n (rd16_n),
        .wr8_n (wr8_n), .wr16_n (wr16_n), .wr_data (wr_data),
        .rd_data (rd_data), .lane_hi_oe_n (lane_hi_oe_n),
        .lane_lo_oe_n (lane_lo_oe_n), .sram_ce_n (sram_ce_n),
        .sram_we_hi_n (sram_we_hi_n), .sram_we_lo_n (sram_we_lo_n),
        .sram_oe_n (sram_oe_n), .board_sel_n (board_sel_n)
    );

    // Driver: apply one cycle at the falling edge, predict, push.
    task automatic cyc(input logic inta, input logic inp, input logic outp,
                       input logic memr, input logic sync, input logic phn,
                       input logic [23:0] a, input logic r8, input logic r16,
                       input logic w8, input logic w16, input logic [15:0] wd,
                       input string tag);
        obs_t e;
        logic sel, act, anyq;
        logic [15:0] w;
        @(negedge clk);
        st_inta = inta; st_inp = inp; st_out = outp; st_memr = memr;
        st_sync = sync; phantom_n = phn; addr = a;
        rd8_n = r8; rd16_n = r16; wr8_n = w8; wr16_n = w16; wr_data = wd;
        sel  = !inta && !inp && !outp && phn && !a[23];
        act  = sel && !sync;
        anyq = !r8 || !r16 || !w8 || !w16;
        w    = shadow[a[22]][a[6:1]];
        e.sel_n   = !sel;
        e.hi_n    = !(act && ((!r8 && a[0]) || !r16 || !w16));
        e.lo_n    = !(act && !r8 && !a[0]);
        e.ce_n[0] = !(act && anyq && !a[22]);
        e.ce_n[1] = !(act && anyq && a[22]);
        e.we_hi_n = !(act && (!w16 || (!w8 && a[0])));
        e.we_lo_n = !(act && (!w16 || (!w8 && !a[0])));
        e.oe_n    = !(act && memr && (!r8 || !r16));
        if (e.oe_n)       e.data = 16'h0000;
        else if (!r16)    e.data = w;
        else if (a[0])    e.data = {8'h00, w[15:8]};
        else              e.data = {8'h00, w[7:0]};
        if (rst_n && !e.we_hi_n) shadow[a[22]][a[6:1]][15:8] = w16 ? wd[7:0] : wd[15:8];
        if (rst_n && !e.we_lo_n) shadow[a[22]][a[6:1]][7:0]  = wd[7:0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic rd16(input logic [23:0] a, input string tag);
        cyc(0, 0, 0, 1, 0, 1, a, 1, 0, 1, 1, 16'h0, tag);
    endtask
    task automatic rd8(input logic [23:0] a, input string tag);
        cyc(0, 0, 0, 1, 0, 1, a, 0, 1, 1, 1, 16'h0, tag);
    endtask
    task automatic wr16(input logic [23:0] a, input logic [15:0] d, input string tag);
        cyc(0, 0, 0, 0, 0, 1, a, 1, 1, 1, 0, d, tag);
    endtask
    task automatic wr8(input logic [23:0] a, input logic [7:0] d, input string tag);
        cyc(0, 0, 0, 0, 0, 1, a, 1, 1, 0, 1, {8'hEE, d}, tag);
    endtask

    // Monitor: compare observed outputs one time unit after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                obs_t  e, got;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                got = '{sel_n: board_sel_n, hi_n: lane_hi_oe_n, lo_n: lane_lo_oe_n,
                        ce_n: sram_ce_n, we_hi_n: sram_we_hi_n, we_lo_n: sram_we_lo_n,
                        oe_n: sram_oe_n, data: rd_data};
                checks++;
                if (got !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, got, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        cyc(0, 0, 0, 0, 0, 1, 24'h0, 1, 1, 1, 1, 16'h0, "R10 reset idle");
        cyc(0, 0, 0, 1, 0, 1, 24'h2, 1, 0, 1, 1, 16'h0, "R10 reset blocks nothing on enables");
        @(negedge clk);
        rst_n = 1'b1;
        // Seed both banks with known words (R9, R7).
        for (int i = 0; i < 8; i++) begin
            wr16(24'h000000 | (i << 1), 16'h1100 + 16'(i * 16'h0101), "R9 seed bank0");
            wr16(24'h400000 | (i << 1), 16'hA000 + 16'(i * 16'h0203), "R7 seed bank1");
        end
        for (int i = 0; i < 8; i++) begin
            rd16(24'h000000 | (i << 1), "R9 readback bank0");
            rd16(24'h400000 | (i << 1), "R7 readback bank1");
        end
        // 16-bit write with odd A0: A0 plays no part (R9).
        wr16(24'h000011, 16'hBEEF, "R9 odd A0 word write");
        rd16(24'h000010, "R9 odd A0 readback");
        // Byte writes and byte reads (R8, R4, R5).
        wr8(24'h000007, 8'h5A, "R8 odd byte write");
        rd16(24'h000006, "R8 odd byte only changed");
        wr8(24'h000006, 8'hC3, "R8 even byte write");
        rd16(24'h000006, "R8 even byte only changed");
        rd8(24'h000007, "R4 odd 8-bit read");
        rd8(24'h000006, "R5 even 8-bit read");
        rd8(24'h400005, "R4 odd 8-bit read bank1");
        wr8(24'h400004, 8'h77, "R8 bank1 even write");
        rd16(24'h400004, "R8 bank1 readback");
        // Memory-read status off: lane on, SRAM output off (R10).
        cyc(0, 0, 0, 0, 0, 1, 24'h000004, 1, 0, 1, 1, 16'h0, "R10 no memr");
        // Sync phase with read and write (R6).
        cyc(0, 0, 0, 1, 1, 1, 24'h000006, 0, 1, 1, 1, 16'h0, "R6 sync read");
        cyc(0, 0, 0, 0, 1, 1, 24'h000002, 1, 1, 1, 0, 16'hDEAD, "R6 sync write");
        rd16(24'h000002, "R6 word kept");
        // Status deselect (R1).
        cyc(1, 0, 0, 1, 0, 1, 24'h000002, 1, 0, 1, 1, 16'h0, "R1 inta read");
        cyc(0, 1, 0, 0, 0, 1, 24'h000004, 1, 1, 1, 0, 16'h1234, "R1 inp write");
        cyc(0, 0, 1, 0, 0, 1, 24'h000004, 1, 1, 0, 1, 16'h0099, "R1 out write");
        rd16(24'h000004, "R1 word kept");
        // Phantom same cycle as a write (R2).
        cyc(0, 0, 0, 0, 0, 0, 24'h000008, 1, 1, 1, 0, 16'h4321, "R2 phantom write");
        cyc(0, 0, 0, 1, 0, 0, 24'h000008, 0, 1, 1, 1, 16'h0, "R2 phantom read");
        rd16(24'h000008, "R2 word kept");
        // Upper half: aliases would hit word 0x0A of bank0 (R3, R11).
        cyc(0, 0, 0, 0, 0, 1, 24'h80000A, 1, 1, 1, 0, 16'hFACE, "R3 upper write");
        rd16(24'h00000A, "R3 word kept");
        for (int i = 0; i < 4; i++) begin
            rd16(24'h800000 + 24'(i * 24'h123457), "R3 upper read lanes off");
            rd8(24'h800001 + 24'(i * 24'h100000), "R3 upper byte read lanes off");
        end
        // Aliasing above the stored index (R11).
        wr16(24'h000100 | 24'h0C, 16'h0F0F, "R11 alias write");
        rd16(24'h00000C, "R11 alias readback");
        // Idle, no qualifier: select low but nothing enabled (R7).
        cyc(0, 0, 0, 1, 0, 1, 24'h400002, 1, 1, 1, 1, 16'h0, "R7 no qualifier");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule